// File: doc/BRIEF.md
# Debug Control and Status Register

This block is the 32-bit control and status word of an on-chip debug unit. Two agents reach it. The processor has a write-only path that only accepts supervisor writes. The external debug port can both read and write it. The word gathers the reasons the core entered debug mode into sticky flags. The causes are a catastrophic double fault, a hardware trigger match, a halt instruction and the external breakpoint pin. The word also tracks a two-level hardware breakpoint sequence as a four-bit status code and reports a fixed revision number.

The debug tool polls the register through the debug port. Each debug-port read returns the current value, and the cause flags are cleared in the next cycle. A resume (GO) command clears the resumable causes but keeps the fault flag. Two control bits leave the block as plain levels. One holds the trace outputs quiet. The other blocks processor writes to the debug registers, and only the debug port can change it. The breakpoint comparators, the trace logic and the serial transport are outside the block. They reach it only as single-cycle strobes.

Top module: `dbg_csr_unit`

## Requirements
- R1: After reset, `dbg_rdata` is 32'h0090_0000 and both `trace_quiet` and `cpu_wr_inhibit` are 0.
- R2: Each cause strobe sets a sticky flag, visible from the next cycle. The flags sit at these bits: fault at bit 27, trigger at bit 26, halt at bit 25, breakpoint pin at bit 24.
- R3: A debug-port read returns the flags as they stood before the read. All four flags read 0 in the following cycle.
- R4: A GO command clears bits 26, 25 and 24. It leaves bit 27 unchanged.
- R5: A cause strobe that arrives in the same cycle as a clearing read or a GO command wins, and its flag ends set.
- R6: Bits 31:28 hold the breakpoint code: 0000 idle, 0001 waiting for level 1, 0010 level 1 hit, 0101 waiting for level 2, 0110 level 2 hit. An arm strobe moves the code to 0001. A level-1 hit in 0001 moves it to 0101 when level 2 is enabled and to 0010 when it is not. A level-2 hit in 0101 moves it to 0110.
- R7: A debug-port read resets the code to 0000 in only two cases: the code is 0110, or the code is 0010 with level 2 disabled. Any other read leaves the code unchanged.
- R8: A trigger-definition write strobe resets the code to 0000. An arm strobe in the same cycle takes priority and gives 0001.
- R9: Bits 23:20 always read 1001 and bits 19:18 always read 0. Writes from either port never change bits 31:18.
- R10: A debug-port write loads bit 17, which drives `trace_quiet`, and bit 16, which drives `cpu_wr_inhibit`.
- R11: A supervisor processor write loads bit 17 and the writable lower bits, and never changes bit 16. A non-supervisor processor write has no effect.
- R12: While bit 16 is 1, processor writes have no effect.
- R13: Bits 15:8 and 6:4 are read/write storage that resets to 0. Bits 7 and 3:0 read 0. When both ports write in the same cycle, the debug-port value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_supv | input | 1 | Processor is in supervisor mode |
| cpu_wdata | input | 32 | Processor write data |
| dbg_wr_en | input | 1 | Debug-port write strobe |
| dbg_rd_en | input | 1 | Debug-port read strobe (clears status) |
| dbg_wdata | input | 32 | Debug-port write data |
| dbg_rdata | output | 32 | Register value as seen by the debug port |
| ev_fault | input | 1 | Catastrophic-halt strobe |
| ev_trig | input | 1 | Hardware-trigger halt strobe |
| ev_halt | input | 1 | Halt-instruction strobe |
| ev_bkpt_pin | input | 1 | Breakpoint-pin halt strobe |
| go_cmd | input | 1 | Resume command strobe |
| tdr_wr | input | 1 | Trigger-definition write strobe |
| bp_arm | input | 1 | Breakpoint arm strobe |
| bp_l2_en | input | 1 | Level-2 breakpoint enabled |
| bp_l1_hit | input | 1 | Level-1 comparator match |
| bp_l2_hit | input | 1 | Level-2 comparator match |
| trace_quiet | output | 1 | Hold trace status/data outputs quiet |
| cpu_wr_inhibit | output | 1 | Block processor writes to debug registers |

## Verification
The bench builds the block with its default parameters: revision 1001 and writable lower mask 16'hFF70. With only four cause inputs, it drives all sixteen strobe combinations on their own and against a clearing read or a GO. A walking one across all 32 data bits, sent from each port in turn, reaches every reserved, read-only and writable position. The breakpoint code is stepped through every state with level 2 enabled and disabled, so that a read lands in each state.

// File: rtl/dbgcsr_pkg.sv
package dbgcsr_pkg;

  localparam int CAUSE_N  = 4;
  localparam int CZ_BKPT  = 0;
  localparam int CZ_HALT  = 1;
  localparam int CZ_TRIG  = 2;
  localparam int CZ_FAULT = 3;

  typedef enum logic [3:0] {
    BP_IDLE  = 4'b0000,
    BP_WAIT1 = 4'b0001,
    BP_HIT1  = 4'b0010,
    BP_WAIT2 = 4'b0101,
    BP_HIT2  = 4'b0110
  } bp_code_e;

endpackage

// File: rtl/dbgcsr_cause_flags.sv
module dbgcsr_cause_flags #(
  parameter int            N      = 4,
  parameter logic [N-1:0]  GO_CLR = {1'b0, {(N-1){1'b1}}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         rd_clr,
  input  logic         go,
  output logic [N-1:0] flags
);

  logic [N-1:0] flag_q;
  logic [N-1:0] flag_nxt;
  logic [N-1:0] flag_en;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // set wins over any clear in the same cycle
    always_comb begin
      flag_en[i]  = ev[i] | rd_clr | (go & GO_CLR[i]);
      flag_nxt[i] = ev[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag_q[i] <= 1'b0;
      else if (flag_en[i])
        flag_q[i] <= flag_nxt[i];
    end

    a_r2_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> flag_q[i]);

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !ev[i]) |=> !flag_q[i]);

    if (GO_CLR[i]) begin : g_goclr
      a_r4_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ev[i]) |=> !flag_q[i]);
    end else begin : g_gokeep
      a_r4_go_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !rd_clr && flag_q[i]) |=> flag_q[i]);
    end
  end

  assign flags = flag_q;

endmodule

// File: rtl/dbgcsr_bkpt_seq.sv
module dbgcsr_bkpt_seq
  import dbgcsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       l2_en,
  input  logic       l1_hit,
  input  logic       l2_hit,
  input  logic       tdr_clr,
  input  logic       rd_clr,
  output logic [3:0] code
);

  bp_code_e state_q;
  bp_code_e state_nxt;

  always_comb begin
    state_nxt = state_q;
    if (arm) begin
      state_nxt = BP_WAIT1;
    end else if (tdr_clr) begin
      state_nxt = BP_IDLE;
    end else begin
      unique case (state_q)
        BP_WAIT1: if (l1_hit) state_nxt = l2_en ? BP_WAIT2 : BP_HIT1;
        BP_WAIT2: if (l2_hit) state_nxt = BP_HIT2;
        BP_HIT1:  if (rd_clr && !l2_en) state_nxt = BP_IDLE;
        BP_HIT2:  if (rd_clr) state_nxt = BP_IDLE;
        default:  state_nxt = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= BP_IDLE;
    else
      state_q <= state_nxt;
  end

  assign code = state_q;

  a_r8_arm_wins: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (code == 4'b0001));

  a_r8_tdr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tdr_clr && !arm) |=> (code == 4'b0000));

  a_r7_read_keeps_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !arm && !tdr_clr && !l1_hit && !l2_hit &&
     (code == 4'b0001 || code == 4'b0101)) |=> $stable(code));

  a_r6_level2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 4'b0101 && l2_hit && !arm && !tdr_clr) |=> (code == 4'b0110));

endmodule

// File: rtl/dbgcsr_ctrl_regs.sv
module dbgcsr_ctrl_regs #(
  parameter logic [15:0] LOW_MASK = 16'hFF70
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic        cpu_supv,
  input  logic [17:0] cpu_wdata,
  input  logic        dbg_wr,
  input  logic [17:0] dbg_wdata,
  output logic        quiet,
  output logic        inhibit,
  output logic [15:0] low
);

  logic        quiet_q, quiet_nxt, quiet_en;
  logic        inhibit_q, inhibit_nxt, inhibit_en;
  logic        cpu_ok;
  logic        low_en;
  logic [15:0] low_q;
  logic [15:0] low_nxt;
  logic        unused_wbits;

  // debug port has priority; processor path gated by mode and inhibit
  always_comb begin
    cpu_ok      = cpu_wr & cpu_supv & ~inhibit_q & ~dbg_wr;
    quiet_en    = dbg_wr | cpu_ok;
    quiet_nxt   = dbg_wr ? dbg_wdata[17] : cpu_wdata[17];
    inhibit_en  = dbg_wr;
    inhibit_nxt = dbg_wdata[16];
    low_en      = dbg_wr | cpu_ok;
    low_nxt     = dbg_wr ? dbg_wdata[15:0] : cpu_wdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      quiet_q <= 1'b0;
    else if (quiet_en)
      quiet_q <= quiet_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      inhibit_q <= 1'b0;
    else if (inhibit_en)
      inhibit_q <= inhibit_nxt;
  end

  for (genvar b = 0; b < 16; b++) begin : g_low
    if (LOW_MASK[b]) begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          low_q[b] <= 1'b0;
        else if (low_en)
          low_q[b] <= low_nxt[b];
      end
    end else begin : g_zero
      assign low_q[b] = 1'b0;
    end
  end

  assign unused_wbits = ^(low_nxt & ~LOW_MASK);

  assign quiet   = quiet_q;
  assign inhibit = inhibit_q;
  assign low     = low_q;

  a_r11_inhibit_debug_only: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_wr |=> $stable(inhibit_q));

  a_r12_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_q && !dbg_wr) |=> ($stable(low_q) && $stable(quiet_q)));

  a_r11_user_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_supv && !dbg_wr) |=> ($stable(low_q) && $stable(quiet_q)));

  a_r13_debug_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr |=> (low_q == $past(dbg_wdata[15:0] & LOW_MASK)));

endmodule

// File: rtl/dbg_csr_unit.sv
module dbg_csr_unit
  import dbgcsr_pkg::*;
#(
  parameter logic [3:0]  REV_LEVEL   = 4'b1001,
  parameter logic [15:0] LOW_RW_MASK = 16'hFF70
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr_en,
  input  logic        cpu_supv,
  input  logic [31:0] cpu_wdata,
  input  logic        dbg_wr_en,
  input  logic        dbg_rd_en,
  input  logic [31:0] dbg_wdata,
  output logic [31:0] dbg_rdata,
  input  logic        ev_fault,
  input  logic        ev_trig,
  input  logic        ev_halt,
  input  logic        ev_bkpt_pin,
  input  logic        go_cmd,
  input  logic        tdr_wr,
  input  logic        bp_arm,
  input  logic        bp_l2_en,
  input  logic        bp_l1_hit,
  input  logic        bp_l2_hit,
  output logic        trace_quiet,
  output logic        cpu_wr_inhibit
);

  logic [CAUSE_N-1:0] cause_ev;
  logic [CAUSE_N-1:0] cause_flags;
  logic [3:0]         bp_code;
  logic               quiet;
  logic               inhibit;
  logic [15:0]        low_bits;
  logic               unused_hi;

  always_comb begin
    cause_ev            = '0;
    cause_ev[CZ_BKPT]   = ev_bkpt_pin;
    cause_ev[CZ_HALT]   = ev_halt;
    cause_ev[CZ_TRIG]   = ev_trig;
    cause_ev[CZ_FAULT]  = ev_fault;
  end

  dbgcsr_cause_flags #(
    .N      (CAUSE_N),
    .GO_CLR (4'b0111)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (cause_ev),
    .rd_clr (dbg_rd_en),
    .go     (go_cmd),
    .flags  (cause_flags)
  );

  dbgcsr_bkpt_seq u_bkpt (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (bp_arm),
    .l2_en   (bp_l2_en),
    .l1_hit  (bp_l1_hit),
    .l2_hit  (bp_l2_hit),
    .tdr_clr (tdr_wr),
    .rd_clr  (dbg_rd_en),
    .code    (bp_code)
  );

  dbgcsr_ctrl_regs #(
    .LOW_MASK (LOW_RW_MASK)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr_en),
    .cpu_supv  (cpu_supv),
    .cpu_wdata (cpu_wdata[17:0]),
    .dbg_wr    (dbg_wr_en),
    .dbg_wdata (dbg_wdata[17:0]),
    .quiet     (quiet),
    .inhibit   (inhibit),
    .low       (low_bits)
  );

  // status fields are read-only from both ports
  assign unused_hi = ^{cpu_wdata[31:18], dbg_wdata[31:18]};

  always_comb begin
    dbg_rdata = {bp_code,
                 cause_flags[CZ_FAULT], cause_flags[CZ_TRIG],
                 cause_flags[CZ_HALT],  cause_flags[CZ_BKPT],
                 REV_LEVEL, 2'b00, quiet, inhibit, low_bits};
  end

  assign trace_quiet    = quiet;
  assign cpu_wr_inhibit = inhibit;

  a_r5_event_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rd_en && ev_trig) |=> dbg_rdata[26]);

  a_r10_quiet_follows_debug: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr_en |=> (trace_quiet == $past(dbg_wdata[17])));

endmodule

// File: tb/dbg_csr_unit_test.sv
module dbg_csr_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr_en, cpu_supv;
  logic [31:0] cpu_wdata;
  logic        dbg_wr_en, dbg_rd_en;
  logic [31:0] dbg_wdata;
  logic [31:0] dbg_rdata;
  logic        ev_fault, ev_trig, ev_halt, ev_bkpt_pin;
  logic        go_cmd, tdr_wr, bp_arm, bp_l2_en, bp_l1_hit, bp_l2_hit;
  logic        trace_quiet, cpu_wr_inhibit;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_csr_unit uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_supv(cpu_supv), .cpu_wdata(cpu_wdata),
    .dbg_wr_en(dbg_wr_en), .dbg_rd_en(dbg_rd_en), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata),
    .ev_fault(ev_fault), .ev_trig(ev_trig), .ev_halt(ev_halt),
    .ev_bkpt_pin(ev_bkpt_pin), .go_cmd(go_cmd), .tdr_wr(tdr_wr),
    .bp_arm(bp_arm), .bp_l2_en(bp_l2_en), .bp_l1_hit(bp_l1_hit),
    .bp_l2_hit(bp_l2_hit), .trace_quiet(trace_quiet),
    .cpu_wr_inhibit(cpu_wr_inhibit)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_ev(input logic [3:0] p);
    {ev_fault, ev_trig, ev_halt, ev_bkpt_pin} = p;
  endtask

  task automatic dbg_write(input logic [31:0] d);
    dbg_wr_en = 1'b1; dbg_wdata = d;
    tick();
    dbg_wr_en = 1'b0; dbg_wdata = '0;
  endtask

  task automatic cpu_write(input logic [31:0] d, input logic supv);
    cpu_wr_en = 1'b1; cpu_wdata = d; cpu_supv = supv;
    tick();
    cpu_wr_en = 1'b0; cpu_wdata = '0; cpu_supv = 1'b0;
  endtask

  task automatic dbg_read();
    dbg_rd_en = 1'b1;
    tick();
    dbg_rd_en = 1'b0;
  endtask

  task automatic bp_code_chk(input string tag, input logic [3:0] exp);
    chk(tag, {28'd0, dbg_rdata[31:28]}, {28'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cpu_wr_en = 0; cpu_supv = 0; cpu_wdata = '0;
    dbg_wr_en = 0; dbg_rd_en = 0; dbg_wdata = '0;
    set_ev(4'h0);
    go_cmd = 0; tdr_wr = 0; bp_arm = 0; bp_l2_en = 0; bp_l1_hit = 0; bp_l2_hit = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 rdata", dbg_rdata, 32'h0090_0000);
    chk("R1 outputs", {30'd0, trace_quiet, cpu_wr_inhibit}, 32'd0);

    // R2 / R3 every strobe combination, then a clearing read
    for (int p = 0; p < 16; p++) begin
      set_ev(p[3:0]);
      tick();
      set_ev(4'h0);
      chk("R2 flags set", {28'd0, dbg_rdata[27:24]}, p);
      dbg_rd_en = 1'b1;
      #1;
      chk("R3 read returns old", {28'd0, dbg_rdata[27:24]}, p);
      tick();
      dbg_rd_en = 1'b0;
      chk("R3 cleared after read", {28'd0, dbg_rdata[27:24]}, 32'd0);
    end

    // R4 GO clears all but fault
    for (int p = 0; p < 16; p++) begin
      set_ev(p[3:0]);
      tick();
      set_ev(4'h0);
      go_cmd = 1'b1;
      tick();
      go_cmd = 1'b0;
      chk("R4 go clear", {28'd0, dbg_rdata[27:24]}, p & 8);
      dbg_read();
    end

    // R5 strobe colliding with read or GO
    for (int p = 0; p < 16; p++) begin
      set_ev(4'hF);
      tick();
      set_ev(p[3:0]);
      dbg_rd_en = 1'b1;
      tick();
      set_ev(4'h0);
      dbg_rd_en = 1'b0;
      chk("R5 event vs read", {28'd0, dbg_rdata[27:24]}, p);
      set_ev(4'hF);
      tick();
      set_ev(p[3:0]);
      go_cmd = 1'b1;
      tick();
      set_ev(4'h0);
      go_cmd = 1'b0;
      chk("R5 event vs go", {28'd0, dbg_rdata[27:24]}, p | 8);
      dbg_read();
    end

    // R6 / R7 single-level sequence
    bp_l2_en = 1'b0;
    bp_arm = 1'b1; tick(); bp_arm = 1'b0;
    bp_code_chk("R6 armed", 4'b0001);
    dbg_read();
    bp_code_chk("R7 read keeps 0001", 4'b0001);
    bp_l1_hit = 1'b1; tick(); bp_l1_hit = 1'b0;
    bp_code_chk("R6 level1 hit", 4'b0010);
    bp_l2_en = 1'b1;
    dbg_read();
    bp_code_chk("R7 read keeps 0010 with l2 on", 4'b0010);
    bp_l2_en = 1'b0;
    dbg_read();
    bp_code_chk("R7 read clears 0010", 4'b0000);

    // R6 / R7 two-level sequence
    bp_l2_en = 1'b1;
    bp_arm = 1'b1; tick(); bp_arm = 1'b0;
    bp_l1_hit = 1'b1; tick(); bp_l1_hit = 1'b0;
    bp_code_chk("R6 waiting level2", 4'b0101);
    dbg_read();
    bp_code_chk("R7 read keeps 0101", 4'b0101);
    bp_l2_hit = 1'b1; tick(); bp_l2_hit = 1'b0;
    bp_code_chk("R6 level2 hit", 4'b0110);
    dbg_read();
    bp_code_chk("R7 read clears 0110", 4'b0000);

    // R8 trigger-definition write
    bp_arm = 1'b1; tick(); bp_arm = 1'b0;
    tdr_wr = 1'b1; tick(); tdr_wr = 1'b0;
    bp_code_chk("R8 tdr clears wait", 4'b0000);
    bp_arm = 1'b1; tdr_wr = 1'b1; tick(); bp_arm = 1'b0; tdr_wr = 1'b0;
    bp_code_chk("R8 arm beats tdr", 4'b0001);
    bp_l1_hit = 1'b1; tick(); bp_l1_hit = 1'b0;
    bp_l2_hit = 1'b1; tick(); bp_l2_hit = 1'b0;
    tdr_wr = 1'b1; tick(); tdr_wr = 1'b0;
    bp_code_chk("R8 tdr clears hit", 4'b0000);
    bp_l2_en = 1'b0;

    // R9 / R10 / R13 debug-port walking one
    for (int i = 0; i < 32; i++) begin
      dbg_write(32'd1 << i);
      chk("R9 R13 dbg walk", dbg_rdata, 32'h0090_0000 | ((32'd1 << i) & 32'h0003_FF70));
      chk("R10 outputs", {30'd0, trace_quiet, cpu_wr_inhibit},
          {30'd0, (i == 17), (i == 16)});
    end
    dbg_write(32'hFFFF_FFFF);
    chk("R9 all ones", dbg_rdata, 32'h0093_FF70);
    dbg_write(32'h0);

    // R11 processor walking one
    for (int i = 0; i < 32; i++) begin
      cpu_write(32'd1 << i, 1'b1);
      chk("R11 cpu walk", dbg_rdata, 32'h0090_0000 | ((32'd1 << i) & 32'h0002_FF70));
    end
    cpu_write(32'hFFFF_FFFF, 1'b1);
    chk("R11 cpu all ones", dbg_rdata, 32'h0092_FF70);
    cpu_write(32'h0, 1'b0);
    chk("R11 user write ignored", dbg_rdata, 32'h0092_FF70);

    // R12 inhibit
    dbg_write(32'h0001_0000);
    chk("R12 inhibit set", {31'd0, cpu_wr_inhibit}, 32'd1);
    cpu_write(32'hFFFF_FFFF, 1'b1);
    chk("R12 cpu blocked", dbg_rdata, 32'h0091_0000);

    // R13 both ports same cycle
    dbg_wr_en = 1'b1; dbg_wdata = 32'h0000_0100;
    cpu_wr_en = 1'b1; cpu_supv = 1'b1; cpu_wdata = 32'hFFFF_FFFF;
    tick();
    dbg_wr_en = 1'b0; cpu_wr_en = 1'b0; cpu_supv = 1'b0;
    chk("R13 debug wins", dbg_rdata, 32'h0090_0100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule